// File: doc/BRIEF.md
# TDM Output Time-Slot Switch

This core builds eight serial TDM output streams, each carrying 32 eight-bit channels per frame of 256 bit cycles. It owns a 256-entry data memory that holds the latest byte received for every input channel, and a connection memory with one entry per output slot. Each entry has a low byte and a three-bit control field. For every output slot the core picks one of two sources. In switched mode the low byte is the address of a data-memory byte to forward. In message mode the low byte itself is sent, and it is repeated every frame until software rewrites it.

The core also produces a per-stream, per-slot drive enable for external tri-state buffers, and a separate one-bit control stream. That stream carries one control flag per slot and runs one channel ahead of the data. A global drive-enable input and a global force-message input override the per-slot settings. Writers fill the memories through plain write ports. Bit timing is one clock per bit cell, and a frame-sync pulse realigns the frame.

Top module: `tdm_slot_switch`

## Requirements
- R1: A frame has 256 bit cycles and a position counter runs 0 to 255, wrapping to 0. A cycle with frame_sync high makes the next cycle position 0. Position 0 is also the first cycle after reset. Channel c of every stream occupies positions 8c to 8c+7.
- R2: Slot addresses in both memories are {stream[2:0], channel[4:0]}. In switched mode the slot carries the data-memory byte whose address is the slot's low byte: bits 7-5 give the source stream and bits 4-0 give the source channel.
- R3: When control bit 2 of a slot is 1, the slot carries its own low byte every frame, whatever the data memory holds.
- R4: While force_msg is 1, every slot behaves as if its control bits 2 and 0 were both 1.
- R5: ser_oe[s] is 0 for every stream while drive_en is 0, and this takes effect in the same cycle. With drive_en high and force_msg low, ser_oe[s] follows control bit 0 of the current slot (1 drives).
- R6: Each slot byte is sent on ser_out[s] with bit 7 at position 8c and bit 0 at position 8c+7.
- R7: At position 8c+s, ctl_out carries control bit 1 of stream s, channel c+1. At channel 31 it carries the bit of channel 0.
- R8: While rst is high, and in the first cycle after it falls, ser_oe is all zero and ctl_out is 0.
- R9: Any mapping is served in full. This includes every output slot reading the same input byte, and a full permutation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-cell clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Next cycle becomes frame position 0 |
| drive_en | input | 1 | Global output drive enable |
| force_msg | input | 1 | Global message mode for all slots |
| dm_we | input | 1 | Data-memory write strobe |
| dm_waddr | input | 8 | Data-memory write address {stream, channel} |
| dm_wdata | input | 8 | Data-memory write byte |
| cm_lo_we | input | 1 | Connection low-byte write strobe |
| cm_hi_we | input | 1 | Connection control-field write strobe |
| cm_waddr | input | 8 | Connection slot address {stream, channel} |
| cm_lo_wdata | input | 8 | Connection low byte |
| cm_hi_wdata | input | 3 | Control field: bit 2 message, bit 1 control stream, bit 0 drive |
| ser_out | output | 8 | Serial data, one bit per stream |
| ser_oe | output | 8 | Drive enable, one bit per stream |
| ctl_out | output | 1 | Control bit stream, one channel ahead |

## Verification
A random table mixes switched and message slots with random enables and control flags. That run checks address decode, source choice and the control stream together. Two directed tables follow. In one, every output reads a single input byte. In the other, a reversed permutation maps each slot to a different input. They separate a non-blocking fetch from one that drops or repeats reads. A message-only table is then checked again after the whole data memory is rewritten, which shows that message slots ignore switched data. Further runs set the global message flag over random control fields, drop the drive enable mid-frame, resync the frame in mid-channel and reset the core mid-run.

// File: rtl/tss_pkg.sv
package tss_pkg;
  // per-slot control field: bit 2 message, bit 1 control stream, bit 0 drive
  typedef struct packed {
    logic msg;
    logic ctl;
    logic en;
  } slot_ctl_t;
endpackage

// File: rtl/tss_ram.sv
module tss_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tss_timer.sv
module tss_timer #(
  parameter int AW   = 8,
  parameter int SB   = 3,
  parameter int LEAD = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_sync,
  output logic [AW-1:0] pos,
  output logic [AW-1:0] rd_addr,
  output logic          load
);
  logic [AW-1:0] ahead;

  always_ff @(posedge clk) begin
    if (rst || frame_sync) pos <= '0;
    else                   pos <= pos + 1'b1;
  end

  // fetch one stream per bit cycle, LEAD cycles ahead of transmission
  assign ahead   = pos + AW'(LEAD);
  assign rd_addr = {ahead[SB-1:0], ahead[AW-1:SB]};
  assign load    = &pos[SB-1:0];
endmodule

// File: rtl/tss_lane.sv
module tss_lane #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          load,
  input  logic [DW-1:0] byte_in,
  input  logic          en_in,
  input  logic          drive_en,
  output logic          sdo,
  output logic          oe
);
  logic [DW-1:0] stage_b, shreg;
  logic          stage_e, slot_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_b <= '0;
      stage_e <= 1'b0;
      shreg   <= '0;
      slot_en <= 1'b0;
    end else begin
      if (wr) begin
        stage_b <= byte_in;
        stage_e <= en_in;
      end
      if (load) begin
        shreg   <= stage_b;
        slot_en <= stage_e;
      end else begin
        shreg   <= {shreg[DW-2:0], 1'b0};
      end
    end
  end

  assign sdo = shreg[DW-1];
  assign oe  = slot_en & drive_en;
endmodule

// File: rtl/tdm_slot_switch.sv
module tdm_slot_switch #(
  parameter int SB = 3,
  parameter int CB = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_sync,
  input  logic               drive_en,
  input  logic               force_msg,
  input  logic               dm_we,
  input  logic [SB+CB-1:0]   dm_waddr,
  input  logic [SB+CB-1:0]   dm_wdata,
  input  logic               cm_lo_we,
  input  logic               cm_hi_we,
  input  logic [SB+CB-1:0]   cm_waddr,
  input  logic [SB+CB-1:0]   cm_lo_wdata,
  input  logic [2:0]         cm_hi_wdata,
  output logic [(1<<SB)-1:0] ser_out,
  output logic [(1<<SB)-1:0] ser_oe,
  output logic               ctl_out
);
  import tss_pkg::*;
  localparam int AW   = SB + CB;
  localparam int NS   = 1 << SB;
  localparam int LEAD = NS + 3;

  logic [AW-1:0] pos, rd_addr, lo_rd, dm_rd, lo_d2;
  logic [2:0]    hi_raw;
  slot_ctl_t     hi_rd;
  logic          load;
  logic [SB-1:0] s_d1, s_d2;
  logic          v_d1, v_d2, msg_d2, en_d2, ctl_d1;
  logic [AW-1:0] st_byte;
  logic          st_en;

  tss_timer #(.AW(AW), .SB(SB), .LEAD(LEAD)) u_tmr (
    .clk(clk), .rst(rst), .frame_sync(frame_sync),
    .pos(pos), .rd_addr(rd_addr), .load(load)
  );

  tss_ram #(.AW(AW), .DW(AW)) u_cm_lo (
    .clk(clk), .we(cm_lo_we), .waddr(cm_waddr), .wdata(cm_lo_wdata),
    .raddr(rd_addr), .rdata(lo_rd)
  );

  tss_ram #(.AW(AW), .DW(3)) u_cm_hi (
    .clk(clk), .we(cm_hi_we), .waddr(cm_waddr), .wdata(cm_hi_wdata),
    .raddr(rd_addr), .rdata(hi_raw)
  );
  assign hi_rd = slot_ctl_t'(hi_raw);

  // second stage: the low byte read addresses the data memory
  tss_ram #(.AW(AW), .DW(AW)) u_dm (
    .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
    .raddr(lo_rd), .rdata(dm_rd)
  );

  always_ff @(posedge clk) begin
    s_d1   <= rd_addr[AW-1:CB];
    s_d2   <= s_d1;
    lo_d2  <= lo_rd;
    msg_d2 <= hi_rd.msg;
    en_d2  <= hi_rd.en;
    if (rst) begin
      v_d1    <= 1'b0;
      v_d2    <= 1'b0;
      ctl_d1  <= 1'b0;
      ctl_out <= 1'b0;
    end else begin
      v_d1    <= 1'b1;
      v_d2    <= v_d1;
      ctl_d1  <= hi_rd.ctl;
      ctl_out <= ctl_d1;
    end
  end

  assign st_byte = (force_msg || msg_d2) ? lo_d2 : dm_rd;
  assign st_en   = force_msg || en_d2;

  for (genvar i = 0; i < NS; i++) begin : g_lane
    tss_lane #(.DW(AW)) u_lane (
      .clk(clk), .rst(rst),
      .wr(v_d2 && (s_d2 == SB'(i))),
      .load(load), .byte_in(st_byte), .en_in(st_en),
      .drive_en(drive_en), .sdo(ser_out[i]), .oe(ser_oe[i])
    );
  end
endmodule

// File: rtl/tdm_slot_switch_chk.sv
module tdm_slot_switch_chk #(
  parameter int AW = 8,
  parameter int LB = 3,
  parameter int NS = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_sync,
  input logic          drive_en,
  input logic          force_msg,
  input logic [NS-1:0] ser_oe,
  input logic [AW-1:0] pos
);
  localparam int SETTLE = (1 << AW) + 2 * NS;
  localparam int CW     = $clog2(SETTLE + 1);
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst || !(force_msg && drive_en)) run <= '0;
    else if (run != CW'(SETTLE))         run <= run + 1'b1;
  end

  AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> pos == '0); // R1
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!frame_sync && pos == '1) |=> pos == '0); // R1
  AST_FORCE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    run == CW'(SETTLE) |-> ser_oe == '1); // R4
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pos[LB-1:0] != '0) && $stable(drive_en) |-> $stable(ser_oe)); // R5
  AST_RESET_HIZ: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ser_oe == '0); // R8
endmodule

bind tdm_slot_switch tdm_slot_switch_chk u_chk (
  .clk(clk), .rst(rst), .frame_sync(frame_sync), .drive_en(drive_en),
  .force_msg(force_msg), .ser_oe(ser_oe), .pos(pos)
);

// File: tb/tdm_slot_switch_tb.sv
module tdm_slot_switch_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, frame_sync = 1'b0, drive_en = 1'b1, force_msg = 1'b1;
  logic dm_we = 1'b0, cm_lo_we = 1'b0, cm_hi_we = 1'b0;
  logic [7:0] dm_waddr = '0, dm_wdata = '0, cm_waddr = '0, cm_lo_wdata = '0;
  logic [2:0] cm_hi_wdata = '0;
  logic [7:0] ser_out, ser_oe;
  logic ctl_out;

  tdm_slot_switch u_dut (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .drive_en(drive_en),
    .force_msg(force_msg), .dm_we(dm_we), .dm_waddr(dm_waddr), .dm_wdata(dm_wdata),
    .cm_lo_we(cm_lo_we), .cm_hi_we(cm_hi_we), .cm_waddr(cm_waddr),
    .cm_lo_wdata(cm_lo_wdata), .cm_hi_wdata(cm_hi_wdata),
    .ser_out(ser_out), .ser_oe(ser_oe), .ctl_out(ctl_out)
  );

  logic [7:0] m_lo [256];
  logic [2:0] m_hi [256];
  logic [7:0] m_dm [256];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] ref_pos = '0;

  // frame position per R1
  always @(posedge clk) ref_pos <= (rst || frame_sync) ? 8'd0 : ref_pos + 8'd1;

  function automatic logic [7:0] exp_byte(int s, int c);
    int idx = s * 32 + c;
    if (force_msg || m_hi[idx][2]) return m_lo[idx];
    return m_dm[m_lo[idx]];
  endfunction

  function automatic logic exp_en(int s, int c);
    return force_msg || m_hi[s * 32 + c][0];
  endfunction

  function automatic logic exp_ctl(int p);
    return m_hi[(p % 8) * 32 + ((p / 8 + 1) % 32)][1];
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic push_all();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      dm_we = 1; cm_lo_we = 1; cm_hi_we = 1;
      dm_waddr = 8'(i); cm_waddr = 8'(i);
      dm_wdata = m_dm[i]; cm_lo_wdata = m_lo[i]; cm_hi_wdata = m_hi[i];
    end
    @(negedge clk);
    dm_we = 0; cm_lo_we = 0; cm_hi_we = 0;
  endtask

  task automatic push_dm();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      dm_we = 1; dm_waddr = 8'(i); dm_wdata = m_dm[i];
    end
    @(negedge clk);
    dm_we = 0;
  endtask

  task automatic watch(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      logic [7:0] eo, ed, bt;
      logic ec;
      int p, c, b;
      @(negedge clk);
      p = int'(ref_pos); c = p / 8; b = p % 8;
      for (int s = 0; s < 8; s++) begin
        eo[s] = drive_en & exp_en(s, c);
        bt = exp_byte(s, c);
        ed[s] = bt[7 - b];
      end
      ec = exp_ctl(p);
      n_cmp++;
      if (ser_oe !== eo) begin
        n_bad++;
        $display("FAIL %s/R5 pos %0d oe got %b exp %b", tag, p, ser_oe, eo);
      end
      n_cmp++;
      if ((ser_out & eo) !== (ed & eo)) begin
        n_bad++;
        $display("FAIL %s/R6 pos %0d data got %b exp %b", tag, p, ser_out & eo, ed & eo);
      end
      n_cmp++;
      if (ctl_out !== ec) begin
        n_bad++;
        $display("FAIL R7 pos %0d ctl got %b exp %b", p, ctl_out, ec);
      end
    end
  endtask

  task automatic check_reset(input string when);
    n_cmp++;
    if (ser_oe !== 8'h00 || ctl_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R8 %s oe/ctl got %b/%b exp 00000000/0", when, ser_oe, ctl_out);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd4242));
    // R8: outputs stay undriven under reset even with forced message mode
    repeat (3) @(negedge clk);
    check_reset("during reset");
    rst = 0;
    @(negedge clk);
    check_reset("after release");
    force_msg = 0;

    // random mixed table: R2, R3, R7
    for (int i = 0; i < 256; i++) begin
      m_lo[i] = 8'($urandom); m_hi[i] = 3'($urandom); m_dm[i] = 8'($urandom);
    end
    push_all();
    repeat (280) @(negedge clk);
    watch(512, "R2");

    // R9 broadcast: every output slot reads input byte 0x5A
    for (int i = 0; i < 256; i++) begin
      m_lo[i] = 8'h5A; m_hi[i] = 3'b001 | 3'(i[0] << 1);
    end
    push_all();
    repeat (280) @(negedge clk);
    watch(512, "R9");

    // R9 reversed permutation, all driven, alternating control flag
    for (int i = 0; i < 256; i++) begin
      m_lo[i] = 8'(255 - i); m_hi[i] = 3'b001 | 3'(((i >> 3) & 1) << 1);
    end
    push_all();
    repeat (280) @(negedge clk);
    watch(512, "R9");

    // R3 message slots, then new data memory must not show through
    for (int i = 0; i < 256; i++) begin
      m_lo[i] = 8'($urandom); m_hi[i] = 3'b101;
    end
    push_all();
    repeat (280) @(negedge clk);
    watch(256, "R3");
    for (int i = 0; i < 256; i++) m_dm[i] = 8'($urandom);
    push_dm();
    watch(512, "R3");

    // R4 global message mode over random control fields
    for (int i = 0; i < 256; i++) m_hi[i] = 3'($urandom);
    push_all();
    force_msg = 1;
    repeat (280) @(negedge clk);
    watch(512, "R4");
    force_msg = 0;
    repeat (280) @(negedge clk);
    watch(256, "R2");

    // R5 drive enable low acts at once, mid-frame
    drive_en = 0;
    watch(300, "R5");
    drive_en = 1;
    watch(100, "R5");

    // R1 resync in the middle of a channel
    while (ref_pos != 8'd100) @(negedge clk);
    frame_sync = 1;
    @(negedge clk);
    frame_sync = 0;
    repeat (280) @(negedge clk);
    watch(512, "R1");

    // R8 reset in mid-run
    rst = 1;
    @(negedge clk);
    check_reset("mid-run reset");
    rst = 0;
    @(negedge clk);
    check_reset("after mid-run release");
    repeat (280) @(negedge clk);
    watch(256, "R2");

    finish_up();
  end
endmodule